// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block divides a channel clock through two cascaded counting stages and presents the result as a single output level, `div_o`, in the clock domain of `clk`. Each stage keeps its output at one level for a programmed number of input events, then at the other level for a second programmed number. The first stage counts `clk` cycles. The second stage counts the periods of the first stage, so the overall period is the product of the two stage periods. Each stage can start high or low, can be delayed by a phase offset after a sync release, and can be bypassed.

A channel-level `sync_i` input parks both stages at their start levels and restarts them together, unless a no-sync control bit tells the channel to ignore it. With sync ignored, a force-high control can pin the output high. Software reaches the settings through a small write port and a combinational read port with four 8-bit registers. A duty-cycle-correction disable flag is kept there for the neighbouring analog logic; the flag has no effect inside this block.

All counting is synchronous to `clk`. A bypassed stage passes on every event it receives. When both stages are bypassed, `div_o` is held at 1, which tells downstream gating to pass the input clock as it is.

Top module: `twostage_clkdiv`

## Requirements
- R1: After reset the registers read back as follows. Address 0 reads 0x22 and address 1 reads 0x11; in each, bits [7:4] are the low count and bits [3:0] the high count of stage 1 or stage 2. Address 2 reads 0x00, with bits [3:0] the stage 1 offset and bits [7:4] the stage 2 offset. Address 3 reads 0x00, with bit0 the stage 1 start level, bit1 the stage 2 start level, bit2 the stage 1 bypass, bit3 the stage 2 bypass, bit4 no-sync, bit5 force-high and bit6 the correction-disable flag. `div_o` is 0 after reset.
- R2: Stage 1 holds its level low for (low+1) `clk` cycles and high for (high+1) `clk` cycles.
- R3: Stage 2 advances once each time stage 1 goes from low to high. It holds its low and high levels for (low+1) and (high+1) such events. With neither stage bypassed, `div_o` follows the stage 2 level.
- R4: While `sync_i` is 1 and no-sync is 0, both stages sit at their start levels with their counts cleared. Counting resumes from that point on the first cycle after `sync_i` falls.
- R5: After a sync release, each stage holds its start level for an extra (offset) input events before its first counted phase begins.
- R6: A start bit of 1 makes a stage begin high after sync, and its periods then start at the high level. A start bit of 0 makes it begin low.
- R7: New high and low counts written during operation take effect only when a stage returns to its start level, or at sync. The stage's current phase always completes with the old count.
- R8: A bypassed stage stops counting and forwards every input event. If stage 1 is bypassed, stage 2 counts `clk` cycles. If stage 2 is bypassed, `div_o` follows stage 1. If both are bypassed, `div_o` is 1.
- R9: With no-sync set to 1, `sync_i` has no effect on either stage.
- R10: Force-high drives `div_o` to 1 only while no-sync is also 1. Otherwise force-high has no effect on `div_o`.
- R11: The correction-disable flag is stored and read back and does not change `div_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Channel sync, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| div_o | output | 1 | Divided output level |

## Verification
Two pairs of events can fall in the same clock edge. The first is a register write landing on the edge that releases sync or that ends a stage period: does the new count apply to the phase that starts there, or only to a later one? The second is stage 2 taking its step on the very edge where stage 1 rises. The bench provokes the first pair by issuing writes in the cycle that `sync_i` falls and at arbitrary points inside running periods. A behavioural model that tracks the remaining events per phase decides every edge, and `div_o` is compared against it on every cycle.

// File: rtl/twostage_clkdiv.sv
module twostage_clkdiv #(
  parameter int CW   = 4,
  parameter int DEF1 = 2,
  parameter int DEF2 = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [2*CW-1:0] wr_data_i,
  input  logic [1:0]      rd_addr_i,
  output logic [2*CW-1:0] rd_data_o,
  output logic            div_o
);
  localparam int DW = 2 * CW;

  typedef struct packed {
    logic          lvl;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wt;
    logic [CW-1:0] hi;
    logic [CW-1:0] lo;
  } stage_t;

  logic [CW-1:0] hi1_r, lo1_r, hi2_r, lo2_r, ph1_r, ph2_r;
  logic st1_r, st2_r, byp1_r, byp2_r, nosync_r, force_r, dccoff_r;
  stage_t s1_q, s2_q, s1_d, s2_d;
  logic hold, rise1, ev2;

  function automatic stage_t step(stage_t c, logic ev, logic byp, logic hld,
                                  logic start, logic [CW-1:0] hi_n,
                                  logic [CW-1:0] lo_n, logic [CW-1:0] ph);
    stage_t n = c;
    if (hld) begin
      n.lvl = start;
      n.cnt = '0;
      n.wt  = ph;
      n.hi  = hi_n;
      n.lo  = lo_n;
    end else if (ev && !byp) begin
      if (c.wt != '0) begin
        n.wt = c.wt - 1'b1;
      end else if (c.cnt == (c.lvl ? c.hi : c.lo)) begin
        n.lvl = ~c.lvl;
        n.cnt = '0;
        if (~c.lvl == start) begin
          n.hi = hi_n;
          n.lo = lo_n;
        end
      end else begin
        n.cnt = c.cnt + 1'b1;
      end
    end
    return n;
  endfunction

  assign hold  = sync_i & ~nosync_r;
  assign s1_d  = step(s1_q, 1'b1, byp1_r, hold, st1_r, hi1_r, lo1_r, ph1_r);
  assign rise1 = ~s1_q.lvl & s1_d.lvl;
  assign ev2   = byp1_r | rise1;
  assign s2_d  = step(s2_q, ev2, byp2_r, hold, st2_r, hi2_r, lo2_r, ph2_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '{lvl: 1'b0, cnt: '0, wt: '0, hi: CW'(DEF1), lo: CW'(DEF1)};
      s2_q <= '{lvl: 1'b0, cnt: '0, wt: '0, hi: CW'(DEF2), lo: CW'(DEF2)};
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi1_r <= CW'(DEF1); lo1_r <= CW'(DEF1);
      hi2_r <= CW'(DEF2); lo2_r <= CW'(DEF2);
      ph1_r <= '0; ph2_r <= '0;
      {dccoff_r, force_r, nosync_r, byp2_r, byp1_r, st2_r, st1_r} <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        2'd0: {lo1_r, hi1_r} <= wr_data_i;
        2'd1: {lo2_r, hi2_r} <= wr_data_i;
        2'd2: {ph2_r, ph1_r} <= wr_data_i;
        default: {dccoff_r, force_r, nosync_r, byp2_r, byp1_r, st2_r, st1_r} <= wr_data_i[6:0];
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      2'd0: rd_data_o = {lo1_r, hi1_r};
      2'd1: rd_data_o = {lo2_r, hi2_r};
      2'd2: rd_data_o = {ph2_r, ph1_r};
      default: rd_data_o = DW'({dccoff_r, force_r, nosync_r, byp2_r, byp1_r, st2_r, st1_r});
    endcase
  end

  assign div_o = (nosync_r & force_r) ? 1'b1 :
                 byp2_r ? (byp1_r | s1_q.lvl) : s2_q.lvl;
endmodule

module twostage_clkdiv_chk #(parameter int CW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [2*CW-1:0] wr_data,
  input logic          byp1,
  input logic          byp2,
  input logic          start2,
  input logic          lvl1,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] hi1,
  input logic [CW-1:0] lo1,
  input logic [CW-1:0] wt1,
  input logic          div
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt1 <= (lvl1 ? hi1 : lo1));

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !byp1 && !byp2 && !wr_en) |=> (div == $past(start2)));

  assert_offset_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !byp1 && wt1 != '0) |=> $stable(lvl1));

  assert_force_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[4] && wr_data[5]) |=> div);
endmodule

bind twostage_clkdiv twostage_clkdiv_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .byp1(byp1_r), .byp2(byp2_r), .start2(st2_r),
  .lvl1(s1_q.lvl), .cnt1(s1_q.cnt), .hi1(s1_q.hi), .lo1(s1_q.lo), .wt1(s1_q.wt),
  .div(div_o)
);

// File: tb/twostage_clkdiv_bench.sv
module twostage_clkdiv_bench;
  logic clk = 0, rst_n = 0, sync_i = 0, wr_en_i = 0;
  logic [1:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic div_o;
  int checks = 0, fails = 0;
  string tag = "R1";

  twostage_clkdiv u_twostage_clkdiv (.*);

  always #10 clk = ~clk;

  int m_lvl[2] = '{0, 0};
  int m_rem[2] = '{3, 2};
  int m_dly[2] = '{0, 0};
  int m_ahi[2] = '{2, 1};
  int m_alo[2] = '{2, 1};
  int r_hi[2] = '{2, 1};
  int r_lo[2] = '{2, 1};
  int r_ph[2] = '{0, 0};
  bit r_st[2] = '{0, 0};
  bit r_byp[2] = '{0, 0};
  bit r_ns = 0, r_fh = 0, r_dcc = 0;

  task automatic m_stage(int s, bit hld, bit ev);
    if (hld) begin
      m_lvl[s] = r_st[s]; m_dly[s] = r_ph[s];
      m_ahi[s] = r_hi[s]; m_alo[s] = r_lo[s];
      m_rem[s] = (m_lvl[s] != 0 ? m_ahi[s] : m_alo[s]) + 1;
    end else if (ev && !r_byp[s]) begin
      if (m_dly[s] > 0) m_dly[s]--;
      else begin
        m_rem[s]--;
        if (m_rem[s] == 0) begin
          m_lvl[s] = 1 - m_lvl[s];
          if (m_lvl[s] == int'(r_st[s])) begin m_ahi[s] = r_hi[s]; m_alo[s] = r_lo[s]; end
          m_rem[s] = (m_lvl[s] != 0 ? m_ahi[s] : m_alo[s]) + 1;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = '{0, 0}; m_rem = '{3, 2}; m_dly = '{0, 0};
      m_ahi = '{2, 1}; m_alo = '{2, 1}; r_hi = '{2, 1}; r_lo = '{2, 1};
      r_ph = '{0, 0}; r_st = '{0, 0}; r_byp = '{0, 0};
      r_ns = 0; r_fh = 0; r_dcc = 0;
    end else begin
      bit hld, ev2;
      int old0;
      hld = sync_i && !r_ns;
      old0 = m_lvl[0];
      m_stage(0, hld, 1);
      ev2 = r_byp[0] || (old0 == 0 && m_lvl[0] == 1);
      m_stage(1, hld, ev2);
      if (wr_en_i) begin
        case (wr_addr_i)
          0: begin r_lo[0] = wr_data_i[7:4]; r_hi[0] = wr_data_i[3:0]; end
          1: begin r_lo[1] = wr_data_i[7:4]; r_hi[1] = wr_data_i[3:0]; end
          2: begin r_ph[1] = wr_data_i[7:4]; r_ph[0] = wr_data_i[3:0]; end
          default: begin
            r_st[0] = wr_data_i[0]; r_st[1] = wr_data_i[1];
            r_byp[0] = wr_data_i[2]; r_byp[1] = wr_data_i[3];
            r_ns = wr_data_i[4]; r_fh = wr_data_i[5]; r_dcc = wr_data_i[6];
          end
        endcase
      end
    end
  end

  function automatic bit m_out();
    if (r_ns && r_fh) return 1;
    if (r_byp[1]) return r_byp[0] ? 1'b1 : (m_lvl[0] != 0);
    return m_lvl[1] != 0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (div_o !== m_out()) begin
      fails++;
      $display("FAIL %s div_o actual %b expected %b at %0t", tag, div_o, m_out(), $time);
    end
  end

  function automatic logic [7:0] m_reg(int a);
    case (a)
      0: return {4'(r_lo[0]), 4'(r_hi[0])};
      1: return {4'(r_lo[1]), 4'(r_hi[1])};
      2: return {4'(r_ph[1]), 4'(r_ph[0])};
      default: return {1'b0, r_dcc, r_fh, r_ns, r_byp[1], r_byp[0], r_st[1], r_st[0]};
    endcase
  endfunction

  task automatic rd_check(int a, string t);
    rd_addr_i = 2'(a);
    #1;
    checks++;
    if (rd_data_o !== m_reg(a)) begin
      fails++;
      $display("FAIL %s reg %0d actual %h expected %h", t, a, rd_data_o, m_reg(a));
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en_i = 1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_pulse(int n);
    @(negedge clk); sync_i = 1;
    run(n);
    sync_i = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    run(3);
    #1;
    checks++;
    if (div_o !== 1'b0) begin fails++; $display("FAIL R1 div_o in reset actual %b expected 0", div_o); end
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    for (int a = 0; a < 4; a++) rd_check(a, "R1");

    tag = "R2 R3";
    run(200);

    tag = "R7";
    wr(0, 8'h40);
    run(37);
    wr(1, 8'h02);
    run(150);

    tag = "R4";
    sync_pulse(5);
    run(120);

    tag = "R5 R6";
    wr(2, 8'h23);
    wr(3, 8'h03);
    sync_pulse(4);
    run(200);
    tag = "R5";
    wr(2, 8'h0F);
    sync_pulse(2);
    run(150);

    tag = "R7 sync";
    @(negedge clk); sync_i = 1;
    run(3);
    sync_i = 0; wr_en_i = 1; wr_addr_i = 0; wr_data_i = 8'h13;
    @(negedge clk); wr_en_i = 0;
    run(150);

    tag = "R8";
    wr(3, 8'h04);
    run(80);
    wr(3, 8'h08);
    run(80);
    wr(3, 8'h0C);
    run(20);
    wr(3, 8'h00);
    run(60);

    tag = "R9";
    wr(3, 8'h10);
    sync_pulse(10);
    run(60);

    tag = "R10";
    wr(3, 8'h30);
    run(30);
    wr(3, 8'h20);
    sync_pulse(3);
    run(60);

    tag = "R11";
    wr(3, 8'h40);
    run(60);
    rd_check(3, "R11");
    for (int a = 0; a < 3; a++) rd_check(a, "R11");
    run(5);
    finish_up();
  end
endmodule